// File: doc/BRIEF.md
# I2C Master SCL Rate Generator

This block turns the system clock into the serial clock waveform of an I2C bus master. A prescaler divides the system clock by four to make a time base. A phase counter then counts time-base units through a low phase and a high phase of unequal length. Both lengths are a power-of-two term that depends on a 3-bit rate select, plus a fixed offset. The offset is 29 units for the low phase and 6 units for the high phase, so the low phase is always the longer one. One full period is 2^n + 35 units, where n runs from 4 to 10.

The serial clock leaves the block as an open-drain pull-down enable. While the enable is high, SCL is held low. While it is low, the line is released. A transfer sequencer uses the block in three ways:
- It drives the run input to start and stop the clock.
- It changes SDA on the strobe that marks the start of each low phase.
- It samples SDA on the strobe that marks the start of each high phase.

The rate select is captured once per period, when a low phase begins. Both phases of a period therefore always share one rate.

Top module: `scl_rate_gen`

## Requirements
- R1: During reset and in the first cycle after it, scl_pull_o, low_stb_o and high_stb_o are all 0, so the line is released.
- R2: While run_i is sampled 0, the next cycle has scl_pull_o = 0 and both strobes at 0. The clock is restarted by the first edge that samples run_i = 1. In the cycle after that edge, scl_pull_o = 1 and low_stb_o = 1.
- R3: For a rate_sel_i code c from 0 to 6, let n = 4 + c. Each low phase then keeps scl_pull_o = 1 for exactly PRESCALE * (2^(n-1) + 29) consecutive cycles.
- R4: For the same code and n, each high phase keeps scl_pull_o = 0 for exactly PRESCALE * (2^(n-1) + 6) consecutive cycles while run_i stays 1.
- R5: Code 7 (binary 111) gives the same phase lengths as code 6, that is n = 10.
- R6: low_stb_o is 1 for exactly one cycle, which is the first cycle of every low phase, and it is 0 at all other times.
- R7: high_stb_o is 1 for exactly one cycle, which is the first cycle of every high phase, and it is 0 at all other times.
- R8: rate_sel_i is captured only when a low phase starts. If the code changes during a period, the current low phase and the following high phase keep the old lengths, and the new code applies from the next low phase.
- R9: low_stb_o and high_stb_o are never 1 in the same cycle. Dropping run_i in the middle of either phase releases the line in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | 1 runs the clock; 0 stops it with the line released |
| rate_sel_i | input | SEL_W | Rate code; n = N_MIN + code, with codes above CODE_MAX clamped to CODE_MAX |
| scl_pull_o | output | 1 | Open-drain enable; 1 pulls SCL low |
| low_stb_o | output | 1 | One-cycle pulse in the first cycle of each low phase (SDA update point) |
| high_stb_o | output | 1 | One-cycle pulse in the first cycle of each high phase (SDA sample point) |

## Verification
The bench builds the block with PRESCALE = 2 and keeps every other parameter at its default. This halves the length of every period, so all eight rate codes can be swept, each over two full periods, with cycle-exact counts. The counts are compared against PRESCALE * (2^(n-1) + offset), which the bench computes from the code. Within the same run, the bench also changes the code mid-period and stops the clock during each phase.

// File: rtl/scl_rate_gen.sv
module scl_rate_gen #(
  parameter int PRESCALE = 4,
  parameter int N_MIN    = 4,
  parameter int CODE_MAX = 6,
  parameter int SEL_W    = 3,
  parameter int LOW_OFS  = 29,
  parameter int HIGH_OFS = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_i,
  input  logic [SEL_W-1:0] rate_sel_i,
  output logic             scl_pull_o,
  output logic             low_stb_o,
  output logic             high_stb_o
);

  localparam int N_TOP   = N_MIN + CODE_MAX;
  localparam int LEN_MAX = (1 << (N_TOP - 1)) + LOW_OFS;
  localparam int CNT_W   = $clog2(LEN_MAX + 1);
  localparam int PRE_W   = (PRESCALE > 1) ? $clog2(PRESCALE) : 1;

  logic             active_q, low_q;
  logic [PRE_W-1:0] pre_q;
  logic [CNT_W-1:0] unit_q;
  logic [SEL_W-1:0] code_q;
  logic             low_stb_q, high_stb_q;

  wire [SEL_W-1:0] code_eff  = (rate_sel_i > SEL_W'(CODE_MAX)) ? SEL_W'(CODE_MAX) : rate_sel_i;
  wire [CNT_W-1:0] pow_term  = CNT_W'(1) << (CNT_W'(N_MIN - 1) + CNT_W'(code_q));
  wire [CNT_W-1:0] phase_len = pow_term + (low_q ? CNT_W'(LOW_OFS) : CNT_W'(HIGH_OFS));
  wire             pre_wrap  = (pre_q == PRE_W'(PRESCALE - 1));
  wire             phase_end = pre_wrap && (unit_q == phase_len - CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      low_q      <= 1'b0;
      pre_q      <= '0;
      unit_q     <= '0;
      code_q     <= '0;
      low_stb_q  <= 1'b0;
      high_stb_q <= 1'b0;
    end else if (!run_i) begin
      active_q   <= 1'b0;
      low_q      <= 1'b0;
      pre_q      <= '0;
      unit_q     <= '0;
      low_stb_q  <= 1'b0;
      high_stb_q <= 1'b0;
    end else if (!active_q) begin
      active_q   <= 1'b1;
      low_q      <= 1'b1;
      pre_q      <= '0;
      unit_q     <= '0;
      code_q     <= code_eff;
      low_stb_q  <= 1'b1;
      high_stb_q <= 1'b0;
    end else begin
      low_stb_q  <= 1'b0;
      high_stb_q <= 1'b0;
      if (pre_wrap) begin
        pre_q <= '0;
        if (phase_end) begin
          unit_q <= '0;
          low_q  <= !low_q;
          if (!low_q) begin
            code_q    <= code_eff;
            low_stb_q <= 1'b1;
          end else begin
            high_stb_q <= 1'b1;
          end
        end else begin
          unit_q <= unit_q + CNT_W'(1);
        end
      end else begin
        pre_q <= pre_q + PRE_W'(1);
      end
    end
  end

  assign scl_pull_o = active_q & low_q;
  assign low_stb_o  = low_stb_q;
  assign high_stb_o = high_stb_q;

  AST_STOP_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
    !run_i |=> (!scl_pull_o && !low_stb_o && !high_stb_o)); // R2
  AST_LOW_STB_AT_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scl_pull_o) |-> low_stb_o); // R6
  AST_LOW_STB_IN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    low_stb_o |-> scl_pull_o); // R6
  AST_HIGH_STB_AT_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    high_stb_o |-> (!scl_pull_o && $past(scl_pull_o))); // R7
  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(low_stb_o && high_stb_o)); // R9
  AST_CODE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !low_stb_o |-> $stable(code_q)); // R8
  AST_UNIT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    active_q |-> (unit_q < phase_len)); // R3

endmodule

// File: tb/tb_scl_rate_gen.sv
module tb_scl_rate_gen;
  localparam int PS  = 2;
  localparam int LIM = 10000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0;
  logic [2:0] sel = 3'd0;
  logic scl, lstb, hstb;
  int checks = 0;
  int errors = 0;
  int cyc = 0;

  scl_rate_gen #(.PRESCALE(PS)) dut (
    .clk(clk), .rst_n(rst_n), .run_i(run), .rate_sel_i(sel),
    .scl_pull_o(scl), .low_stb_o(lstb), .high_stb_o(hstb));

  always #10 clk = ~clk;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int exp_len(input int code, input bit low);
    int n = 4 + ((code > 6) ? 6 : code);
    return PS * ((1 << (n - 1)) + (low ? 29 : 6));
  endfunction

  task automatic measure(output int lo, output int hi);
    lo = 0;
    hi = 0;
    while (scl === 1'b1 && lo < LIM) begin
      if (lo > 0 && lstb !== 1'b0) check(0, "R6 low strobe extra", lo, 0);
      if (hstb !== 1'b0) check(0, "R7 high strobe in low", lo, 0);
      lo++;
      @(negedge clk);
    end
    check(hstb === 1'b1 && lstb === 1'b0, "R7 high strobe at high start", hstb, 1);
    while (scl === 1'b0 && hi < LIM) begin
      if (hi > 0 && hstb !== 1'b0) check(0, "R7 high strobe extra", hi, 0);
      if (lstb !== 1'b0) check(0, "R6 low strobe in high", hi, 0);
      hi++;
      @(negedge clk);
    end
    check(lstb === 1'b1 && hstb === 1'b0, "R6 low strobe at low start", lstb, 1);
  endtask

  task automatic start(input int code);
    @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    sel = 3'(code);
    run = 1'b1;
    @(negedge clk);
    check(scl === 1'b1 && lstb === 1'b1, "R2 restart into low phase", scl, 1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(scl === 1'b0 && lstb === 1'b0 && hstb === 1'b0, "R1 reset state", scl, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(scl === 1'b0 && lstb === 1'b0 && hstb === 1'b0, "R1 after reset", scl, 0);

    for (int c = 0; c < 8; c++) begin
      int lo, hi;
      start(c);
      for (int p = 0; p < 2; p++) begin
        measure(lo, hi);
        if (c == 7) begin
          check(lo == exp_len(6, 1), "R5 code 7 low", lo, exp_len(6, 1));
          check(hi == exp_len(6, 0), "R5 code 7 high", hi, exp_len(6, 0));
        end else begin
          check(lo == exp_len(c, 1), "R3 low length", lo, exp_len(c, 1));
          check(hi == exp_len(c, 0), "R4 high length", hi, exp_len(c, 0));
        end
      end
    end

    begin
      int lo, hi;
      start(0);
      repeat (3) @(negedge clk);
      sel = 3'd6;
      begin
        int lo2 = 3;
        while (scl === 1'b1 && lo2 < LIM) begin lo2++; @(negedge clk); end
        check(lo2 == exp_len(0, 1), "R8 current low keeps old rate", lo2, exp_len(0, 1));
        hi = 0;
        while (scl === 1'b0 && hi < LIM) begin hi++; @(negedge clk); end
        check(hi == exp_len(0, 0), "R8 following high keeps old rate", hi, exp_len(0, 0));
      end
      measure(lo, hi);
      check(lo == exp_len(6, 1), "R8 new rate low", lo, exp_len(6, 1));
      check(hi == exp_len(6, 0), "R8 new rate high", hi, exp_len(6, 0));
    end

    start(1);
    repeat (5) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(scl === 1'b0 && lstb === 1'b0 && hstb === 1'b0, "R9 stop in low releases", scl, 0);
    repeat (20) @(negedge clk);
    check(scl === 1'b0 && lstb === 1'b0 && hstb === 1'b0, "R2 stays released", scl, 0);

    start(1);
    while (scl === 1'b1) @(negedge clk);
    repeat (4) @(negedge clk);
    run = 1'b0;
    @(negedge clk);
    check(scl === 1'b0 && lstb === 1'b0 && hstb === 1'b0, "R9 stop in high quiet", hstb, 0);
    run = 1'b1;
    @(negedge clk);
    check(scl === 1'b1 && lstb === 1'b1 && hstb === 1'b0, "R2 restart after stop", lstb, 1);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=0", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule